// File: doc/BRIEF.md
# Dual FIFO Controller with Threshold Interrupts

This block buffers bytes between a host and a radio datapath in two byte-wide queues of 64 entries each: one feeding the transmitter and one collecting received bytes. The host reaches both queues, plus a small set of configuration and status operations, through a single command port. Each cycle it presents one command code and one data byte. Read results appear on a registered return byte.

The radio side drains the transmit queue through a show-ahead head byte and a pop strobe. It fills the receive queue with a push strobe. Interrupt events are kept as sticky status bits. These events are the transmit level falling to a programmable almost-empty mark, the receive level rising past a programmable almost-full mark, overflow and underflow on either queue, and a packet-done indication from the radio. A host status read clears the bits. An active-low interrupt output is asserted while any status bit enabled in the mask is set. A clear command empties either queue or both in a single cycle. A transmit-active flag is set by a host start command and drops when the radio reports a finished packet with nothing left to send.

Top module: `dual_fifo_ctrl`

## Requirements
- R1: After reset both levels read 0, `rad_tx_empty` is 1, `tx_active` is 0 and `irq_n` is 1. The almost-empty mark resets to 16, the almost-full mark to 48 and the interrupt mask to all ones.
- R2: Command 0x66 with `host_valid` high appends `host_wdata` to the transmit queue, and `tx_count` rises by one after that edge.
- R3: Command 0x77 removes the oldest receive byte and places it on `host_rdata` after that edge, and `rx_count` falls by one. Bytes leave in arrival order.
- R4: Command 0x40 sets the almost-empty mark from `host_wdata`. Status bit 0 is set on the edge where the transmit level goes from above the mark to at or below it, and only then.
- R5: Command 0x41 sets the almost-full mark from `host_wdata`. Status bit 1 is set on the edge where the receive level goes from at or below the mark to above it.
- R6: Command 0x20 returns the 7-bit status on `host_rdata[6:0]` and clears it. Its bit positions are: 0 almost-empty, 1 almost-full, 2 transmit overflow, 3 receive overflow, 4 receive underflow, 5 transmit underflow, 6 packet done. Command 0x42 loads the mask from `host_wdata[6:0]`. `irq_n` is 0 exactly when some status bit and its mask bit are both 1.
- R7: A push into a full queue is dropped and leaves the level at 64. This sets status bit 2 for transmit and bit 3 for receive. A host pop of an empty receive queue returns 0x00 and sets bit 4. A radio pop of an empty transmit queue sets bit 5.
- R8: Command 0x15 empties the receive queue when `host_wdata[0]` is 1 and the transmit queue when `host_wdata[1]` is 1. Both levels are 0 after that single edge for the value 3.
- R9: `rad_tx_data` shows the oldest transmit byte before the edge on which `rad_tx_pop` removes it. `rad_rx_push` appends `rad_rx_data` to the receive queue. Neither level ever exceeds 64.
- R10: Unknown command codes, and any command with `host_valid` low, change neither queue.
- R11: Command 0x31 sets `tx_active`. A `rad_pkt_sent` pulse sets status bit 6. If the transmit queue is empty and no push arrives on that cycle, it also clears `tx_active`. Otherwise `tx_active` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host command present this cycle |
| host_cmd | input | 8 | Host command code |
| host_wdata | input | 8 | Host data or argument byte |
| host_rdata | output | 8 | Registered result of the last pop or status read |
| irq_n | output | 1 | Active-low interrupt |
| rad_tx_pop | input | 1 | Radio removes the transmit head byte |
| rad_tx_data | output | 8 | Transmit head byte (show-ahead) |
| rad_tx_empty | output | 1 | Transmit queue empty |
| rad_rx_push | input | 1 | Radio appends a received byte |
| rad_rx_data | input | 8 | Received byte |
| rad_pkt_sent | input | 1 | Radio finished sending a packet |
| tx_active | output | 1 | Transmit session in progress |
| tx_count | output | 7 | Transmit queue level |
| rx_count | output | 7 | Receive queue level |

## Verification
Every host command and radio strobe takes effect on the one rising edge where it is presented. `host_rdata`, both levels, the status bits and `irq_n` all show the result directly after that edge. `rad_tx_data` is combinational from the head pointer, so it is due before the popping edge. Stimulus is applied and outputs are read at falling edges, so each check reads its result exactly one edge after the stimulus. The bench sweeps every fill level from 0 to 64 in both queues and predicts each level, byte and interrupt state from its own arithmetic.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    typedef enum logic [7:0] {
        CMD_TX_PUSH   = 8'h66,
        CMD_RX_POP    = 8'h77,
        CMD_FIFO_CLR  = 8'h15,
        CMD_STAT_RD   = 8'h20,
        CMD_TX_START  = 8'h31,
        CMD_SET_TXTHR = 8'h40,
        CMD_SET_RXTHR = 8'h41,
        CMD_SET_MASK  = 8'h42
    } cmd_e;

    // One decoded host operation per cycle
    typedef struct packed {
        logic tx_push;
        logic rx_pop;
        logic clr_rx;
        logic clr_tx;
        logic stat_rd;
        logic tx_start;
        logic set_txthr;
        logic set_rxthr;
        logic set_mask;
    } host_op_t;

    // Sticky status, bit 0 at the bottom
    typedef struct packed {
        logic pkt_done;
        logic tx_udf;
        logic rx_udf;
        logic rx_ovf;
        logic tx_ovf;
        logic rx_af;
        logic tx_ae;
    } irq_stat_t;

    // Level moved from above the mark to at or below it
    function automatic logic fell_to(input logic [7:0] cur, input logic [7:0] nxt,
                                     input logic [7:0] mark);
        return (cur > mark) && (nxt <= mark);
    endfunction

    // Level moved from at or below the mark to above it
    function automatic logic rose_past(input logic [7:0] cur, input logic [7:0] nxt,
                                       input logic [7:0] mark);
        return (cur <= mark) && (nxt > mark);
    endfunction

endpackage

// File: rtl/dfc_cmd_decode.sv
module dfc_cmd_decode
    import dfc_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] cmd,
    input  logic [1:0] clr_sel,
    output host_op_t   op
);
    always_comb begin
        op = '0;
        if (valid) begin
            case (cmd)
                CMD_TX_PUSH:   op.tx_push   = 1'b1;
                CMD_RX_POP:    op.rx_pop    = 1'b1;
                CMD_FIFO_CLR: begin
                    op.clr_rx = clr_sel[0];
                    op.clr_tx = clr_sel[1];
                end
                CMD_STAT_RD:   op.stat_rd   = 1'b1;
                CMD_TX_START:  op.tx_start  = 1'b1;
                CMD_SET_TXTHR: op.set_txthr = 1'b1;
                CMD_SET_RXTHR: op.set_rxthr = 1'b1;
                CMD_SET_MASK:  op.set_mask  = 1'b1;
                default:       op = '0;
            endcase
        end
    end
endmodule

// File: rtl/dfc_fifo.sv
module dfc_fifo #(
    parameter  int DEPTH = 64,
    parameter  int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          empty,
    output logic          ovf,
    output logic          udf
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == FULL_LVL);
    assign empty   = (count == '0);
    // A clear in the same cycle wins over any push or pop
    assign do_push = push & ~full  & ~clr;
    assign do_pop  = pop  & ~empty & ~clr;
    assign ovf     = push & full   & ~clr;
    assign udf     = pop  & empty  & ~clr;
    assign dout    = mem[rd_ptr];

    always_comb begin
        if (clr) count_nxt = '0;
        else     count_nxt = count + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= adv(wr_ptr);
            if (do_pop)  rd_ptr <= adv(rd_ptr);
        end
        if (rst) count <= '0;
        else     count <= count_nxt;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/dfc_irq.sv
module dfc_irq
    import dfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stat_rd,
    input  logic      set_mask,
    input  irq_stat_t mask_in,
    input  irq_stat_t events,
    output irq_stat_t status,
    output irq_stat_t mask,
    output logic      irq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            // Events arriving with the read survive it
            status <= (stat_rd ? irq_stat_t'('0) : status) | events;
            if (set_mask) mask <= mask_in;
        end
    end

    assign irq_n = ~|(status & mask);
endmodule

// File: rtl/dual_fifo_ctrl.sv
module dual_fifo_ctrl
    import dfc_pkg::*;
#(
    parameter  int DEPTH     = 64,
    parameter  int TXTHR_RST = 16,
    parameter  int RXTHR_RST = 48,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_valid,
    input  logic [7:0]    host_cmd,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          irq_n,
    input  logic          rad_tx_pop,
    output logic [7:0]    rad_tx_data,
    output logic          rad_tx_empty,
    input  logic          rad_rx_push,
    input  logic [7:0]    rad_rx_data,
    input  logic          rad_pkt_sent,
    output logic          tx_active,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count
);
    // Levels are compared as bytes: DEPTH must stay below 256
    host_op_t      op;
    irq_stat_t     events, status, mask;
    logic [CW-1:0] tx_cnt_nxt, rx_cnt_nxt;
    logic [7:0]    tx_mark, rx_mark, rx_head;
    logic          rx_empty, tx_ovf, tx_udf, rx_ovf, rx_udf;
    logic          unused_wbit;

    assign unused_wbit = host_wdata[7];

    dfc_cmd_decode u_dec (
        .valid   (host_valid),
        .cmd     (host_cmd),
        .clr_sel (host_wdata[1:0]),
        .op      (op)
    );

    dfc_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .clr       (op.clr_tx),
        .push      (op.tx_push),
        .din       (host_wdata),
        .pop       (rad_tx_pop),
        .dout      (rad_tx_data),
        .count     (tx_count),
        .count_nxt (tx_cnt_nxt),
        .empty     (rad_tx_empty),
        .ovf       (tx_ovf),
        .udf       (tx_udf)
    );

    dfc_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clr       (op.clr_rx),
        .push      (rad_rx_push),
        .din       (rad_rx_data),
        .pop       (op.rx_pop),
        .dout      (rx_head),
        .count     (rx_count),
        .count_nxt (rx_cnt_nxt),
        .empty     (rx_empty),
        .ovf       (rx_ovf),
        .udf       (rx_udf)
    );

    always_comb begin
        events          = '0;
        events.tx_ae    = fell_to(8'(tx_count), 8'(tx_cnt_nxt), tx_mark);
        events.rx_af    = rose_past(8'(rx_count), 8'(rx_cnt_nxt), rx_mark);
        events.tx_ovf   = tx_ovf;
        events.rx_ovf   = rx_ovf;
        events.rx_udf   = rx_udf;
        events.tx_udf   = tx_udf;
        events.pkt_done = rad_pkt_sent;
    end

    dfc_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (op.stat_rd),
        .set_mask (op.set_mask),
        .mask_in  (irq_stat_t'(host_wdata[6:0])),
        .events   (events),
        .status   (status),
        .mask     (mask),
        .irq_n    (irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mark    <= 8'(TXTHR_RST);
            rx_mark    <= 8'(RXTHR_RST);
            host_rdata <= '0;
            tx_active  <= 1'b0;
        end else begin
            if (op.set_txthr) tx_mark <= host_wdata;
            if (op.set_rxthr) rx_mark <= host_wdata;
            if (op.rx_pop)
                host_rdata <= rx_empty ? 8'h00 : rx_head;
            else if (op.stat_rd)
                host_rdata <= {1'b0, status};
            if (op.tx_start)
                tx_active <= 1'b1;
            else if (rad_pkt_sent && rad_tx_empty && !op.tx_push)
                tx_active <= 1'b0;
        end
    end
endmodule

// File: rtl/dfc_chk.sv
module dfc_chk #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          host_valid,
    input logic [7:0]    host_cmd,
    input logic [7:0]    host_wdata,
    input logic [7:0]    host_rdata,
    input logic          rad_tx_pop,
    input logic          rad_pkt_sent,
    input logic          tx_active,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    // R9: neither level ever passes the depth
    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= FULL_LVL) && (rx_count <= FULL_LVL));

    // R7: a host push into a full transmit queue is dropped
    p_full_push_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_cmd == 8'h66 && tx_count == FULL_LVL && !rad_tx_pop)
        |=> (tx_count == FULL_LVL));

    // R7: a host pop of an empty receive queue returns zero
    p_empty_pop_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_cmd == 8'h77 && rx_count == '0) |=> (host_rdata == 8'h00));

    // R8: clearing both queues empties them in one edge
    p_clear_both_r8: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_cmd == 8'h15 && host_wdata[1:0] == 2'b11)
        |=> (tx_count == '0 && rx_count == '0));

    // R11: packet done with nothing queued ends the transmit session
    p_tx_stop_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_active && rad_pkt_sent && tx_count == '0 &&
         !(host_valid && (host_cmd == 8'h66 || host_cmd == 8'h31)))
        |=> !tx_active);
endmodule

bind dual_fifo_ctrl dfc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_valid   (host_valid),
    .host_cmd     (host_cmd),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .rad_tx_pop   (rad_tx_pop),
    .rad_pkt_sent (rad_pkt_sent),
    .tx_active    (tx_active),
    .tx_count     (tx_count),
    .rx_count     (rx_count)
);

// File: tb/dual_fifo_ctrl_tb.sv
module dual_fifo_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_valid = 1'b0;
    logic [7:0] host_cmd = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_n;
    logic       rad_tx_pop = 1'b0, rad_rx_push = 1'b0, rad_pkt_sent = 1'b0;
    logic [7:0] rad_tx_data, rad_rx_data = '0;
    logic       rad_tx_empty, tx_active;
    logic [6:0] tx_count, rx_count;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_fifo_ctrl u_dut (
        .clk(clk), .rst(rst),
        .host_valid(host_valid), .host_cmd(host_cmd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_n(irq_n),
        .rad_tx_pop(rad_tx_pop), .rad_tx_data(rad_tx_data), .rad_tx_empty(rad_tx_empty),
        .rad_rx_push(rad_rx_push), .rad_rx_data(rad_rx_data), .rad_pkt_sent(rad_pkt_sent),
        .tx_active(tx_active), .tx_count(tx_count), .rx_count(rx_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic host(input logic [7:0] c, input logic [7:0] d);
        host_valid = 1'b1; host_cmd = c; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic rpop();
        rad_tx_pop = 1'b1; @(negedge clk); rad_tx_pop = 1'b0;
    endtask

    task automatic rpush(input logic [7:0] d);
        rad_rx_push = 1'b1; rad_rx_data = d; @(negedge clk); rad_rx_push = 1'b0;
    endtask

    task automatic pkt();
        rad_pkt_sent = 1'b1; @(negedge clk); rad_pkt_sent = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 tx_count", int'(tx_count), 0);
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 tx_empty", int'(rad_tx_empty), 1);
        chk("R1 tx_active", int'(tx_active), 0);

        // Transmit sweep: fill to full, overflow, drain with almost-empty mark 10
        host(8'h42, 8'h01);
        host(8'h40, 8'd10);
        for (int i = 0; i < DEPTH; i++) begin
            host(8'h66, 8'((i * 5 + 3) & 8'hff));
            chk("R2 tx level", int'(tx_count), i + 1);
        end
        host(8'h66, 8'hAA);
        chk("R7 tx full hold", int'(tx_count), DEPTH);
        chk("R6 irq masked", int'(irq_n), 1);
        host(8'h20, 8'h00);
        chk("R7 tx ovf status", int'(host_rdata), 8'h04);
        host(8'h20, 8'h00);
        chk("R6 status cleared", int'(host_rdata), 8'h00);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R9 tx head", int'(rad_tx_data), (k * 5 + 3) & 8'hff);
            rpop();
            chk("R9 tx level", int'(tx_count), DEPTH - 1 - k);
            chk("R4 almost-empty irq", int'(irq_n), ((DEPTH - 1 - k) <= 10) ? 0 : 1);
        end
        chk("R7 dropped byte absent", int'(rad_tx_empty), 1);
        rpop();
        host(8'h20, 8'h00);
        chk("R7 R4 tx udf and ae", int'(host_rdata), 8'h21);

        // Receive sweep: mark 20
        host(8'h42, 8'h02);
        host(8'h41, 8'd20);
        for (int j = 0; j < DEPTH; j++) begin
            rpush(8'(j ^ 8'h5A));
            chk("R9 rx level", int'(rx_count), j + 1);
            chk("R5 almost-full irq", int'(irq_n), ((j + 1) > 20) ? 0 : 1);
        end
        rpush(8'hEE);
        chk("R7 rx full hold", int'(rx_count), DEPTH);
        host(8'h20, 8'h00);
        chk("R5 R7 rx af and ovf", int'(host_rdata), 8'h0A);
        for (int j = 0; j < DEPTH; j++) begin
            host(8'h77, 8'h00);
            chk("R3 rx byte", int'(host_rdata), j ^ 8'h5A);
            chk("R3 rx level", int'(rx_count), DEPTH - 1 - j);
        end
        host(8'h77, 8'h00);
        chk("R7 empty pop data", int'(host_rdata), 0);
        host(8'h20, 8'h00);
        chk("R7 rx udf", int'(host_rdata), 8'h10);

        // Clear command variants
        for (int i = 0; i < 3; i++) host(8'h66, 8'(i));
        for (int i = 0; i < 5; i++) rpush(8'(i));
        host(8'h15, 8'h01);
        chk("R8 clr rx only rx", int'(rx_count), 0);
        chk("R8 clr rx only tx", int'(tx_count), 3);
        rpush(8'h11); rpush(8'h22);
        host(8'h15, 8'h02);
        chk("R8 clr tx only tx", int'(tx_count), 0);
        chk("R8 clr tx only rx", int'(rx_count), 2);
        for (int i = 0; i < 4; i++) host(8'h66, 8'(i));
        host(8'h15, 8'h03);
        chk("R8 clr both tx", int'(tx_count), 0);
        chk("R8 clr both rx", int'(rx_count), 0);

        // Ignored commands
        host(8'h66, 8'h01); host(8'h66, 8'h02); rpush(8'h33);
        host(8'h99, 8'h03);
        host_cmd = 8'h66; host_wdata = 8'h44; @(negedge clk);
        host_cmd = 8'h77; @(negedge clk);
        host_cmd = 8'h15; host_wdata = 8'h03; @(negedge clk);
        chk("R10 tx unchanged", int'(tx_count), 2);
        chk("R10 rx unchanged", int'(rx_count), 1);
        chk("R10 tx head kept", int'(rad_tx_data), 8'h01);

        // Mask gating
        host(8'h15, 8'h03);
        host(8'h20, 8'h00);
        host(8'h42, 8'h00);
        rpop();
        chk("R6 mask zero irq", int'(irq_n), 1);
        host(8'h42, 8'h20);
        chk("R6 mask udf irq", int'(irq_n), 0);
        host(8'h20, 8'h00);
        chk("R6 read status", int'(host_rdata), 8'h20);
        chk("R6 irq released", int'(irq_n), 1);

        // Transmit session and packet done
        host(8'h66, 8'hA1); host(8'h66, 8'hA2);
        host(8'h31, 8'h00);
        chk("R11 start", int'(tx_active), 1);
        pkt();
        chk("R11 stays with data", int'(tx_active), 1);
        rpop(); rpop();
        pkt();
        chk("R11 stops when empty", int'(tx_active), 0);
        host(8'h20, 8'h00);
        chk("R11 pkt status", int'(host_rdata), 8'h40);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule